// File: doc/BRIEF.md
# Flit Serializer and Deserializer over Degradable Lanes

This block sits between a link layer and a bundle of forwarded-clock lanes. On its transmit side it accepts 80-bit flits, carries each one as four 20-bit phits, and drives them onto 20, 10 or 5 active data lanes according to a configured width. On its receive side it gathers the lane beats back into flits in their original order. Each core cycle models two transfer slots: slot A for the rising edge and slot B for the falling edge.

Lane-failure detection happens elsewhere. This block only receives the chosen width and a request to move the forwarded clock onto a spare data lane. Width and clock placement are latched only at a flit boundary, so a flit never changes shape partway through. Outside the block the transmit pins are wired to the receive pins, directly or through a channel model.

Top module: `lane_phit_link`

## Requirements
- R1: After reset `flit_in_ready`=1, `flit_valid`=0, `tx_beat`=0, both lane vectors are zero, `tx_fclk`=2'b01 and `tx_quad_en`=4'b1111.
- R2: Full width (`cfg_width`=2'b00) sends one phit per slot on lanes 0-19 over two cycles. In cycle k of the flit, slot A carries bits [40k+19:40k] and slot B carries bits [40k+39:40k+20].
- R3: Half width (`cfg_width`=2'b01) uses lanes 0-9 over four cycles and takes two slots per phit. In cycle k, slot A carries bits [20k+9:20k] and slot B carries the next 10 bits.
- R4: Quarter width (`cfg_width`=2'b10 or 2'b11) uses lanes 0-4 over eight cycles and takes four slots per phit. In cycle k, slot A carries bits [10k+4:10k] and slot B carries the next 5 bits.
- R5: `cfg_width` and `cfg_clk_remap` take effect only when no flit is in progress or on the last cycle of a flit. A change made partway through a flit waits for the boundary.
- R6: Lanes are grouped in four quadrants of 5 lanes, with quadrant i on lanes 5i..5i+4. `tx_quad_en` reads 1111 in full width, 0011 in half width and 0001 in quarter width. Every lane in a disabled quadrant is driven 0.
- R7: `tx_fclk` is {slot B, slot A} = 2'b01 and runs continuously. When remap is latched in half or quarter width, `tx_fclk`=2'b00, lane 19 carries 1 in slot A and 0 in slot B, and bit 3 of `tx_quad_en` is set. In full width the remap request has no effect.
- R8: The receiver takes a beat only when `rx_beat`=1 and its clock source reads slot A=1, slot B=0. The clock source is lane 19 when remap is latched in a reduced width, and `rx_fclk` otherwise. Any other beat is ignored and leaves reassembly unchanged.
- R9: `flit_valid` pulses for one cycle per four reassembled phits, on the cycle after the last beat. `flit_out` matches the sent flit bit for bit, and flits arrive in the order they were sent.
- R10: `flit_in_ready` is high during the last cycle of a flit, so flits can stream with no idle cycle between them. A full-width flit is accepted every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Width mode: 00 full, 01 half, 1x quarter |
| cfg_clk_remap | input | 1 | Move the forwarded clock onto lane 19 in reduced widths |
| flit_in | input | 80 | Flit to transmit |
| flit_in_valid | input | 1 | `flit_in` is offered |
| flit_in_ready | output | 1 | A flit is accepted this cycle when valid |
| tx_lanes_a | output | 20 | Data lanes, first-edge slot |
| tx_lanes_b | output | 20 | Data lanes, second-edge slot |
| tx_fclk | output | 2 | Dedicated forwarded-clock lane, {slot B, slot A} |
| tx_beat | output | 1 | Lanes carry flit data this cycle |
| tx_quad_en | output | 4 | Quadrant enables |
| rx_lanes_a | input | 20 | Received lanes, first-edge slot |
| rx_lanes_b | input | 20 | Received lanes, second-edge slot |
| rx_fclk | input | 2 | Received dedicated clock lane, {slot B, slot A} |
| rx_beat | input | 1 | Received beat marker |
| flit_out | output | 80 | Reassembled flit |
| flit_valid | output | 1 | `flit_out` is new this cycle |

## Verification
The assertions assume that `flit_in` stays steady while `flit_in_valid` waits for acceptance. They also assume that the receive pins see the same width and clock placement the transmitter latched, which holds when the lanes loop back with no delay. The stimulus changes configuration only on the falling edge. It drives the receive pins from the transmit pins except in short windows where it forces beats with no valid clock, and those beats must be ignored. Random flits run through every width code with both remap settings, and one directed case changes the width partway through a flit.

// File: rtl/lane_phit_link.sv
module lane_phit_link #(
  parameter int FLIT_W = 80,
  parameter int PHIT_W = 20,
  parameter int QUADS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_clk_remap,
  input  logic [FLIT_W-1:0] flit_in,
  input  logic              flit_in_valid,
  output logic              flit_in_ready,
  output logic [PHIT_W-1:0] tx_lanes_a,
  output logic [PHIT_W-1:0] tx_lanes_b,
  output logic [1:0]        tx_fclk,
  output logic              tx_beat,
  output logic [QUADS-1:0]  tx_quad_en,
  input  logic [PHIT_W-1:0] rx_lanes_a,
  input  logic [PHIT_W-1:0] rx_lanes_b,
  input  logic [1:0]        rx_fclk,
  input  logic              rx_beat,
  output logic [FLIT_W-1:0] flit_out,
  output logic              flit_valid
);

  localparam int PHITS = FLIT_W / PHIT_W;
  localparam int W_H   = PHIT_W / 2;
  localparam int W_Q   = PHIT_W / 4;
  localparam int QW    = PHIT_W / QUADS;
  localparam int NB_F  = PHITS / 2;
  localparam int NB_H  = PHITS;
  localparam int NB_Q  = PHITS * 2;
  localparam int CW    = $clog2(NB_Q);
  localparam int IW    = $clog2(FLIT_W);

  logic [1:0]        mode_q;
  logic              remap_q;
  logic              busy;
  logic [CW-1:0]     tx_cnt, rx_cnt, nb_m1;
  logic [FLIT_W-1:0] tx_buf, tx_sh, rx_buf, rx_next, rx_chunk;
  logic [IW-1:0]     tx_off, rx_off;
  logic              remap_eff, tx_last, boundary, accept;
  logic [1:0]        rx_clk_src;
  logic              take, rx_last;

  assign remap_eff     = remap_q && (mode_q != 2'b00);
  assign tx_last       = busy && (tx_cnt == nb_m1);
  assign boundary      = !busy || tx_last;
  assign flit_in_ready = boundary;
  assign accept        = flit_in_valid && flit_in_ready;
  assign tx_beat       = busy;
  assign tx_fclk       = remap_eff ? 2'b00 : 2'b01;

  always_comb begin
    case (mode_q)
      2'b00:   begin nb_m1 = CW'(NB_F - 1); tx_off = IW'(tx_cnt) * IW'(2 * PHIT_W); rx_off = IW'(rx_cnt) * IW'(2 * PHIT_W); end
      2'b01:   begin nb_m1 = CW'(NB_H - 1); tx_off = IW'(tx_cnt) * IW'(2 * W_H);    rx_off = IW'(rx_cnt) * IW'(2 * W_H);    end
      default: begin nb_m1 = CW'(NB_Q - 1); tx_off = IW'(tx_cnt) * IW'(2 * W_Q);    rx_off = IW'(rx_cnt) * IW'(2 * W_Q);    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 2'b00;
      remap_q <= 1'b0;
      busy    <= 1'b0;
      tx_cnt  <= '0;
      tx_buf  <= '0;
    end else begin
      if (boundary) begin
        mode_q  <= cfg_width[1] ? 2'b10 : cfg_width;
        remap_q <= cfg_clk_remap;
      end
      if (accept) begin
        tx_buf <= flit_in;
        busy   <= 1'b1;
        tx_cnt <= '0;
      end else if (tx_last) begin
        busy   <= 1'b0;
        tx_cnt <= '0;
      end else if (busy) begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  assign tx_sh = tx_buf >> tx_off;

  always_comb begin
    tx_lanes_a = '0;
    tx_lanes_b = '0;
    if (busy) begin
      case (mode_q)
        2'b00: begin
          tx_lanes_a = tx_sh[PHIT_W-1:0];
          tx_lanes_b = tx_sh[2*PHIT_W-1:PHIT_W];
        end
        2'b01: begin
          tx_lanes_a[W_H-1:0] = tx_sh[W_H-1:0];
          tx_lanes_b[W_H-1:0] = tx_sh[2*W_H-1:W_H];
        end
        default: begin
          tx_lanes_a[W_Q-1:0] = tx_sh[W_Q-1:0];
          tx_lanes_b[W_Q-1:0] = tx_sh[2*W_Q-1:W_Q];
        end
      endcase
    end
    if (remap_eff) begin
      tx_lanes_a[PHIT_W-1] = 1'b1;
      tx_lanes_b[PHIT_W-1] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < QUADS; i++) begin
      case (mode_q)
        2'b00:   tx_quad_en[i] = 1'b1;
        2'b01:   tx_quad_en[i] = (i < QUADS / 2);
        default: tx_quad_en[i] = (i < QUADS / 4);
      endcase
    end
    if (remap_eff) tx_quad_en[QUADS-1] = 1'b1;
  end

  assign rx_clk_src = remap_eff ? {rx_lanes_b[PHIT_W-1], rx_lanes_a[PHIT_W-1]} : rx_fclk;
  assign take       = rx_beat && (rx_clk_src == 2'b01);
  assign rx_last    = take && (rx_cnt == nb_m1);

  always_comb begin
    case (mode_q)
      2'b00:   rx_chunk = FLIT_W'({rx_lanes_b, rx_lanes_a});
      2'b01:   rx_chunk = FLIT_W'({rx_lanes_b[W_H-1:0], rx_lanes_a[W_H-1:0]});
      default: rx_chunk = FLIT_W'({rx_lanes_b[W_Q-1:0], rx_lanes_a[W_Q-1:0]});
    endcase
    rx_next = rx_buf | (rx_chunk << rx_off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt     <= '0;
      rx_buf     <= '0;
      flit_out   <= '0;
      flit_valid <= 1'b0;
    end else begin
      flit_valid <= 1'b0;
      if (rx_last) begin
        flit_out   <= rx_next;
        flit_valid <= 1'b1;
        rx_buf     <= '0;
        rx_cnt     <= '0;
      end else if (take) begin
        rx_buf <= rx_next;
        rx_cnt <= rx_cnt + 1'b1;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |=> !flit_valid);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_last) |=> ($stable(mode_q) && $stable(remap_q)));

  // R7
  clk_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fclk == 2'b00) |-> (tx_lanes_a[PHIT_W-1] && !tx_lanes_b[PHIT_W-1] && tx_quad_en[QUADS-1]));

  // R10
  stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && flit_in_valid) |=> (tx_beat && tx_cnt == '0));

  // R8
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(rx_cnt));

  generate
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
      // R6
      idle_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_quad_en[q] |-> (tx_lanes_a[q*QW +: QW] == '0 && tx_lanes_b[q*QW +: QW] == '0));
    end
  endgenerate

endmodule

// File: tb/lane_phit_link_bench.sv
`timescale 1ns/1ps
module lane_phit_link_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'b00;
  logic        cfg_clk_remap = 1'b0;
  logic [79:0] flit_in = '0;
  logic        flit_in_valid = 1'b0;
  logic        flit_in_ready;
  logic [19:0] tx_a, tx_b;
  logic [1:0]  tx_fclk;
  logic        tx_beat;
  logic [3:0]  tx_quad_en;
  logic [79:0] flit_out;
  logic        flit_valid;

  logic        ovr = 1'b0;
  logic [19:0] ov_a = '0, ov_b = '0;
  logic [1:0]  ov_fclk = 2'b00;
  logic        ov_beat = 1'b0;

  logic [79:0] exp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, acc_cyc = 0;
  bit done = 1'b0;

  localparam logic [2:0] VEC [8] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                     3'b100, 3'b101, 3'b110, 3'b111};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_phit_link u_lane_phit_link (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_clk_remap(cfg_clk_remap),
    .flit_in(flit_in), .flit_in_valid(flit_in_valid), .flit_in_ready(flit_in_ready),
    .tx_lanes_a(tx_a), .tx_lanes_b(tx_b), .tx_fclk(tx_fclk), .tx_beat(tx_beat),
    .tx_quad_en(tx_quad_en),
    .rx_lanes_a(ovr ? ov_a : tx_a), .rx_lanes_b(ovr ? ov_b : tx_b),
    .rx_fclk(ovr ? ov_fclk : tx_fclk), .rx_beat(ovr ? ov_beat : tx_beat),
    .flit_out(flit_out), .flit_valid(flit_valid));

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [79:0] rnd();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  task automatic send(input logic [79:0] f);
    flit_in = f;
    flit_in_valid = 1'b1;
    while (!flit_in_ready) @(negedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    flit_in_valid = 1'b0;
    exp_q.push_back(f);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && flit_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 spurious", flit_out, '0);
      else begin
        logic [79:0] e;
        e = exp_q.pop_front();
        chk(flit_out === e, "R9 order/data", flit_out, e);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [79:0] f;
    int a1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(flit_in_ready && !flit_valid && !tx_beat, "R1 ctl", {77'b0, flit_in_ready, flit_valid, tx_beat}, 80'b100);
    chk(tx_a == 0 && tx_b == 0, "R1 lanes", {40'b0, tx_b, tx_a}, '0);
    chk(tx_fclk == 2'b01 && tx_quad_en == 4'hF, "R1 clk/quad", {74'b0, tx_fclk, tx_quad_en}, {74'b0, 2'b01, 4'hF});

    // R2 full-width mapping and R5 deferral of a mid-flit width change
    f = rnd();
    send(f);
    chk(tx_a == f[19:0] && tx_b == f[39:20], "R2 cycle0", {40'b0, tx_b, tx_a}, {40'b0, f[39:0]});
    cfg_width = 2'b10;
    @(negedge clk);
    chk(tx_a == f[59:40] && tx_b == f[79:60], "R2 cycle1", {40'b0, tx_b, tx_a}, {40'b0, f[79:40]});
    chk(tx_quad_en == 4'hF, "R5 held mid-flit", {76'b0, tx_quad_en}, 80'hF);
    @(negedge clk);
    chk(tx_quad_en == 4'h1, "R5 applied at boundary", {76'b0, tx_quad_en}, 80'h1);
    idle(10);

    // R4 quarter mapping
    f = rnd();
    send(f);
    chk(tx_a == {15'b0, f[4:0]} && tx_b == {15'b0, f[9:5]}, "R4 cycle0", {40'b0, tx_b, tx_a}, {60'b0, 5'b0, f[9:5], 15'b0, f[4:0]});
    idle(12);

    // R3 half mapping and R6 quadrant enables
    cfg_width = 2'b01;
    @(negedge clk);
    chk(tx_quad_en == 4'h3, "R6 half quads", {76'b0, tx_quad_en}, 80'h3);
    f = rnd();
    send(f);
    chk(tx_a == {10'b0, f[9:0]} && tx_b == {10'b0, f[19:10]}, "R3 cycle0", {40'b0, tx_b, tx_a}, {40'b0, 10'b0, f[19:10], 10'b0, f[9:0]});
    @(negedge clk);
    chk(tx_a == {10'b0, f[29:20]} && tx_b == {10'b0, f[39:30]}, "R3 cycle1", {40'b0, tx_b, tx_a}, {40'b0, 10'b0, f[39:30], 10'b0, f[29:20]});
    idle(10);

    // R7 clock moved to lane 19 in half width, ignored in full width
    cfg_clk_remap = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(tx_fclk == 2'b00 && tx_a == 20'h80000 && tx_b == 20'h0, "R7 remap half", {38'b0, tx_fclk, tx_b, tx_a}, {38'b0, 2'b00, 20'h0, 20'h80000});
    chk(tx_quad_en == 4'hB, "R7 quad with clock", {76'b0, tx_quad_en}, 80'hB);
    cfg_width = 2'b00;
    @(negedge clk);
    @(negedge clk);
    chk(tx_fclk == 2'b01 && tx_a == 20'h0 && tx_quad_en == 4'hF, "R7 ignored full", {54'b0, tx_fclk, tx_quad_en, tx_a}, {54'b0, 2'b01, 4'hF, 20'h0});
    cfg_clk_remap = 1'b0;
    @(negedge clk);

    // R10 streaming in full width
    send(rnd());
    a1 = acc_cyc;
    send(rnd());
    chk(acc_cyc - a1 == 2, "R10 spacing", 80'(acc_cyc - a1), 80'd2);
    idle(10);

    // R8 beats without a valid clock are ignored (dedicated clock lane)
    ovr = 1'b1; ov_beat = 1'b1; ov_fclk = 2'b00; ov_a = 20'hABCDE; ov_b = 20'h12345;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!flit_valid, "R8 no clock", {79'b0, flit_valid}, '0);
    end
    ovr = 1'b0;
    send(rnd());
    idle(6);
    // R8 with clock on lane 19, dedicated lane toggling but lane 19 low
    cfg_width = 2'b01; cfg_clk_remap = 1'b1;
    idle(2);
    ovr = 1'b1; ov_fclk = 2'b01; ov_a = 20'h003FF; ov_b = 20'h003FF;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!flit_valid, "R8 remapped clock", {79'b0, flit_valid}, '0);
    end
    ovr = 1'b0;
    send(rnd());
    idle(10);

    // R9 random streams in every width code and remap setting (R2 R3 R4 R7)
    for (int v = 0; v < 8; v++) begin
      cfg_width = VEC[v][2:1];
      cfg_clk_remap = VEC[v][0];
      @(negedge clk);
      for (int k = 0; k < 6; k++) begin
        send(rnd());
        if (k == 2) cfg_width = VEC[(v + 3) % 8][2:1];
      end
      idle(24);
    end

    idle(4);
    chk(exp_q.size() == 0, "R9 all delivered", 80'(exp_q.size()), '0);
    finish_up();
  end
endmodule